// File: doc/BRIEF.md
# Serial Framer Frame-Position Strobe Generator

This block produces the frame-position strobes for one bit-serial port of a DS3 or E3 framer. It runs on the port bit clock and uses one bit per clock. It tracks where the current bit sits inside the frame, and from that it decides, for every bit, whether the bit is frame overhead or payload. A mode input selects the DS3 frame structure or the E3 frame structure. With DS3 the port clock runs near 44.736 MHz, and with E3 it runs near 34.368 MHz.

There are two sides. The transmit side tells the upstream source what is coming next. Its strobes lead the serial data by three clocks, so the source has time to switch between its overhead path and its payload path. The receive side marks each bit as it appears. Each side drives one shared strobe pin, and each pin has two controls. A select chooses whether the pin shows the start-of-frame function or the payload data-enable function. An inversion control flips the active level of the pin. The receive side also drives a clock-enable. This enable qualifies the bit clock during payload bits, so downstream logic sees a gated clock without any gate in the clock tree.

The block has no data path. It only produces control and status pins, so there is no flow control and no back-pressure. A synthesis parameter moves the final output register onto the falling clock edge, for ports whose reference clock is inverted.

Top module: `fsg_strobe_gen`

## Requirements
- R1: While `rst` is high, `tx_strobe` equals `tx_pin_inv`, `rx_strobe` equals `rx_pin_inv`, and `rx_gclk_en` is 0, from the first rising edge onward. The same holds in the cycle that follows the last rising edge at which `rst` is sampled high.
- R2: Once `rst` is low, frame bit n is the bit described on the receive side during the cycle after the (n+1)-th rising edge. Bits are counted from 0, and the count wraps at the frame length. Bit 0 is the first overhead bit.
- R3: DS3 mode (`mode_e3` = 0) uses a frame of 4760 bits. The frame is split into 56 consecutive blocks of 85 bits. The first bit of each block is overhead, and the other 84 bits are payload.
- R4: E3 mode (`mode_e3` = 1) uses a frame of 1536 bits. Bits 0 to 11 are overhead, and bits 12 to 1535 are payload.
- R5: With `rx_pin_den_sel` = 0, `rx_strobe` XOR `rx_pin_inv` is 1 only in the cycle that carries frame bit 0.
- R6: With `rx_pin_den_sel` = 1, `rx_strobe` XOR `rx_pin_inv` is 1 exactly in the cycles that carry payload bits.
- R7: `rx_gclk_en` is 1 exactly in the cycles that carry payload bits. It does not depend on the receive select or the receive inversion.
- R8: With `tx_pin_den_sel` = 0, `tx_strobe` XOR `tx_pin_inv` is a single-cycle pulse. It occurs in the cycle that carries bit n, where bit n+3 is frame bit 0. That places it three clocks before the first overhead bit.
- R9: With `tx_pin_den_sel` = 1, `tx_strobe` XOR `tx_pin_inv` is 1 in the cycle of bit n exactly when bit n+3 is a payload bit. So it rises three clocks before each payload run starts and falls three clocks before that run ends.
- R10: A change of `tx_pin_inv` or `rx_pin_inv` takes effect on its pin at the next rising edge, without disturbing the frame count.
- R11: A change of `tx_pin_den_sel` or `rx_pin_den_sel` switches its pin between the start-of-frame function and the data-enable function at the next rising edge, without disturbing the frame count.
- R12: A change of `mode_e3` that is first seen at a rising edge acts as a one-cycle reset at that edge. In the following cycle all outputs are at their R1 levels. Frame bit 0 of the new mode follows one edge later, and the transmit lead of three clocks is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port bit clock, one frame bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| mode_e3 | input | 1 | Frame structure select: 0 selects DS3, 1 selects E3 |
| tx_pin_den_sel | input | 1 | Transmit pin function: 0 selects start-of-frame, 1 selects data-enable |
| tx_pin_inv | input | 1 | Inverts the transmit strobe pin |
| rx_pin_den_sel | input | 1 | Receive pin function: 0 selects start-of-frame, 1 selects data-enable |
| rx_pin_inv | input | 1 | Inverts the receive strobe pin |
| tx_strobe | output | 1 | Transmit strobe, leading the serial data by three clocks |
| rx_strobe | output | 1 | Receive strobe, aligned with the serial data |
| rx_gclk_en | output | 1 | Clock-enable that is high during receive payload bits |

## Verification
Each of the four pin-function combinations is run over more than a full frame in both modes, with several inversion settings. All outputs are compared every cycle against a frame model held in the bench. The start-of-frame runs separate the exact frame length and the three-clock transmit lead from an off-by-one in the wrap. The data-enable runs separate the DS3 block structure from the E3 leading-overhead structure, and show whether the payload edges lead by three. Directed sequences change the mode in mid-frame, toggle the selects and inversions on a live frame, and apply a reset in mid-frame. These show that a restart returns to bit 0 and that pin configuration never moves the frame count.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // DS3 frame geometry: 7 subframes, each of 8 blocks of 85 bits
  localparam int unsigned DS3_BLK_LEN      = 85;
  localparam int unsigned DS3_BLKS_PER_SUB = 8;
  localparam int unsigned DS3_SUBS         = 7;
  localparam int unsigned DS3_FRAME_LEN    = DS3_BLK_LEN * DS3_BLKS_PER_SUB * DS3_SUBS;

  // E3 frame geometry: overhead bits first, then payload
  localparam int unsigned E3_FRAME_LEN = 1536;
  localparam int unsigned E3_OH_BITS   = 12;

  // lead of the transmit strobes over the serial data, in clocks
  localparam int unsigned TX_LEAD = 3;

  typedef enum logic {
    MODE_DS3 = 1'b0,
    MODE_E3  = 1'b1
  } frame_mode_e;

  // per-position decode shared by the counters and the pin stages
  typedef struct packed {
    logic sof;  // position is bit 0 of the frame
    logic pay;  // position carries payload
  } pos_flags_t;

endpackage

// File: rtl/fsg_frame_counter.sv
module fsg_frame_counter
  import fsg_pkg::*;
#(
  parameter int unsigned START    = 0,
  parameter int unsigned BLK_LEN  = DS3_BLK_LEN,
  parameter int unsigned FRAME_A  = DS3_FRAME_LEN,
  parameter int unsigned FRAME_B  = E3_FRAME_LEN,
  parameter int unsigned OH_B     = E3_OH_BITS
) (
  input  logic       clk,
  input  logic       restart,
  input  logic       mode_e3,
  output pos_flags_t flags
);

  localparam int unsigned MAX_LEN = (FRAME_A > FRAME_B) ? FRAME_A : FRAME_B;
  localparam int unsigned POS_W   = $clog2(MAX_LEN);
  localparam int unsigned BLK_W   = $clog2(BLK_LEN);

  localparam logic [POS_W-1:0] LAST_A    = POS_W'(FRAME_A - 1);
  localparam logic [POS_W-1:0] LAST_B    = POS_W'(FRAME_B - 1);
  localparam logic [POS_W-1:0] OH_LIMIT  = POS_W'(OH_B);
  localparam logic [POS_W-1:0] START_POS = POS_W'(START);
  localparam logic [BLK_W-1:0] START_BLK = BLK_W'(START % BLK_LEN);
  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(BLK_LEN - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             frame_wrap;
  logic             blk_wrap;

  always_comb begin
    frame_wrap = (mode_e3 == MODE_E3) ? (pos_q == LAST_B) : (pos_q == LAST_A);
    blk_wrap   = frame_wrap || (blk_q == LAST_BLK);
  end

  always_comb begin
    if (restart) begin
      pos_d = START_POS;
      blk_d = START_BLK;
    end else begin
      pos_d = frame_wrap ? '0 : pos_q + 1'b1;
      blk_d = blk_wrap   ? '0 : blk_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    pos_q <= pos_d;
    blk_q <= blk_d;
  end

  // DS3 overhead is the first bit of every block; E3 overhead leads the frame
  always_comb begin
    flags.sof = (pos_q == '0);
    flags.pay = (mode_e3 == MODE_E3) ? (pos_q >= OH_LIMIT) : (blk_q != '0);
  end

endmodule

// File: rtl/fsg_pin_out.sv
module fsg_pin_out
  import fsg_pkg::*;
#(
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic       clk,
  input  logic       restart,
  input  logic       sel_pay,
  input  logic       inv,
  input  pos_flags_t flags,
  output logic       pin
);

  logic pin_d;
  logic pin_q;

  // restart parks the pin at its inactive level
  always_comb begin
    if (restart) pin_d = inv;
    else         pin_d = (sel_pay ? flags.pay : flags.sof) ^ inv;
  end

  always_ff @(posedge clk) begin
    pin_q <= pin_d;
  end

  generate
    if (FALL_EDGE) begin : g_fall
      logic pin_n;
      always_ff @(negedge clk) begin
        pin_n <= pin_q;
      end
      assign pin = pin_n;
    end else begin : g_rise
      assign pin = pin_q;
    end
  endgenerate

endmodule

// File: rtl/fsg_strobe_gen.sv
module fsg_strobe_gen
  import fsg_pkg::*;
#(
  parameter int unsigned TX_LEAD_CLKS = TX_LEAD,
  parameter int unsigned BLK_LEN      = DS3_BLK_LEN,
  parameter int unsigned SUB_BLKS     = DS3_BLKS_PER_SUB,
  parameter int unsigned SUBS         = DS3_SUBS,
  parameter int unsigned E3_LEN       = E3_FRAME_LEN,
  parameter int unsigned E3_OH        = E3_OH_BITS,
  parameter bit          OUT_ON_FALL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_e3,
  input  logic tx_pin_den_sel,
  input  logic tx_pin_inv,
  input  logic rx_pin_den_sel,
  input  logic rx_pin_inv,
  output logic tx_strobe,
  output logic rx_strobe,
  output logic rx_gclk_en
);

  localparam int unsigned DS3_LEN   = BLK_LEN * SUB_BLKS * SUBS;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_RX   = 0;
  localparam int unsigned LANE_TX   = 1;

  logic       mode_q;
  logic       restart;
  pos_flags_t lane_flags [NUM_LANES];

  always_ff @(posedge clk) begin
    mode_q <= mode_e3;
  end

  // a mode change is treated like a one-cycle reset
  always_comb restart = rst || (mode_e3 != mode_q);

  // receive lane counts the data position, transmit lane runs ahead by the lead
  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      fsg_frame_counter #(
        .START   ((g == LANE_TX) ? TX_LEAD_CLKS : 0),
        .BLK_LEN (BLK_LEN),
        .FRAME_A (DS3_LEN),
        .FRAME_B (E3_LEN),
        .OH_B    (E3_OH)
      ) u_cnt (
        .clk     (clk),
        .restart (restart),
        .mode_e3 (mode_e3),
        .flags   (lane_flags[g])
      );
    end
  endgenerate

  fsg_pin_out #(.FALL_EDGE(OUT_ON_FALL)) u_tx_pin (
    .clk     (clk),
    .restart (restart),
    .sel_pay (tx_pin_den_sel),
    .inv     (tx_pin_inv),
    .flags   (lane_flags[LANE_TX]),
    .pin     (tx_strobe)
  );

  fsg_pin_out #(.FALL_EDGE(OUT_ON_FALL)) u_rx_pin (
    .clk     (clk),
    .restart (restart),
    .sel_pay (rx_pin_den_sel),
    .inv     (rx_pin_inv),
    .flags   (lane_flags[LANE_RX]),
    .pin     (rx_strobe)
  );

  // clock-enable: payload flag, fixed function and polarity
  fsg_pin_out #(.FALL_EDGE(OUT_ON_FALL)) u_gclk_en (
    .clk     (clk),
    .restart (restart),
    .sel_pay (1'b1),
    .inv     (1'b0),
    .flags   (lane_flags[LANE_RX]),
    .pin     (rx_gclk_en)
  );

endmodule

// File: rtl/fsg_strobe_gen_chk.sv
module fsg_strobe_gen_chk (
  input logic clk,
  input logic rst,
  input logic mode_e3,
  input logic tx_pin_den_sel,
  input logic tx_pin_inv,
  input logic rx_pin_den_sel,
  input logic rx_pin_inv,
  input logic tx_strobe,
  input logic rx_strobe,
  input logic rx_gclk_en
);

  // R1: the cycle after a reset edge shows inactive levels
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_strobe == $past(tx_pin_inv)) &&
                   (rx_strobe == $past(rx_pin_inv)) && !rx_gclk_en);

  // R7: in data-enable function the receive pin and the clock-enable agree
  p_gclk_matches_den_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_pin_den_sel)) |->
      (rx_gclk_en == (rx_strobe ^ $past(rx_pin_inv))));

  // R5: receive start-of-frame marks an overhead bit, so the enable is low
  p_rx_sof_overhead_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rx_pin_den_sel) && (rx_strobe != $past(rx_pin_inv)))
      |-> !rx_gclk_en);

  // R8: transmit start-of-frame is a single-cycle pulse
  p_tx_sof_single_r8: assert property (@(posedge clk) disable iff (rst)
    ($stable(tx_pin_den_sel) && $stable(tx_pin_inv) && !tx_pin_den_sel &&
     (tx_strobe != tx_pin_inv)) |=> (tx_strobe == $past(tx_pin_inv)));

  // R12: a mode change parks every output for one cycle
  p_mode_restart_r12: assert property (@(posedge clk) disable iff (rst)
    (mode_e3 != $past(mode_e3)) |=>
      (tx_strobe == $past(tx_pin_inv)) && (rx_strobe == $past(rx_pin_inv)) &&
      !rx_gclk_en);

endmodule

bind fsg_strobe_gen fsg_strobe_gen_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode_e3        (mode_e3),
  .tx_pin_den_sel (tx_pin_den_sel),
  .tx_pin_inv     (tx_pin_inv),
  .rx_pin_den_sel (rx_pin_den_sel),
  .rx_pin_inv     (rx_pin_inv),
  .tx_strobe      (tx_strobe),
  .rx_strobe      (rx_strobe),
  .rx_gclk_en     (rx_gclk_en)
);

// File: tb/fsg_strobe_gen_tb.sv
`timescale 1ns/1ps
module fsg_strobe_gen_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst = 1'b1;
  logic mode = 1'b0;
  logic txs = 1'b0, txi = 1'b0, rxs = 1'b0, rxi = 1'b0;
  logic tx_strobe, rx_strobe, rx_gclk_en;

  int n = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  fsg_strobe_gen u_dut (
    .clk            (clk),
    .rst            (rst),
    .mode_e3        (mode),
    .tx_pin_den_sel (txs),
    .tx_pin_inv     (txi),
    .rx_pin_den_sel (rxs),
    .rx_pin_inv     (rxi),
    .tx_strobe      (tx_strobe),
    .rx_strobe      (rx_strobe),
    .rx_gclk_en     (rx_gclk_en)
  );

  // row: {mode, tx_sel, tx_inv, rx_sel, rx_inv, cycles[15:0]}
  localparam int NROWS = 6;
  localparam logic [20:0] VEC [NROWS] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd4770},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd4770},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd4770},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1560},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1560},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd1560}
  };

  // frame model from R3 and R4
  function automatic int flen(logic m);
    return m ? 1536 : 4760;
  endfunction

  function automatic logic is_pay(logic m, int b);
    int p = b % flen(m);
    if (m) return (p >= 12);
    return ((p % 85) != 0);
  endfunction

  function automatic logic is_sof(logic m, int b);
    return ((b % flen(m)) == 0);
  endfunction

  task automatic chk(logic act, logic exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s bit=%0d: actual=%0b expected=%0b", req, n, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  // one cycle: advance an edge, sample at the falling edge, compare
  task automatic step(string extra);
    string fr;
    string ex;
    logic  tx_e, rx_e, g_e;
    @(posedge clk);
    @(negedge clk);
    fr   = mode ? "R4" : "R3";
    ex   = (n == 0) ? {extra, " R2"} : extra;
    g_e  = is_pay(mode, n);
    rx_e = (rxs ? is_pay(mode, n) : is_sof(mode, n)) ^ rxi;
    tx_e = (txs ? is_pay(mode, n + 3) : is_sof(mode, n + 3)) ^ txi;
    chk(tx_strobe,  tx_e, $sformatf("%s %s%s", txs ? "R9" : "R8", fr, ex));
    chk(rx_strobe,  rx_e, $sformatf("%s %s%s", rxs ? "R6" : "R5", fr, ex));
    chk(rx_gclk_en, g_e,  $sformatf("R7 %s%s", fr, ex));
    n++;
  endtask

  task automatic run(int cnt, string extra);
    for (int k = 0; k < cnt; k++) step(extra);
  endtask

  // called at a falling edge; leaves reset released at a falling edge
  task automatic do_reset(logic m, logic ts, logic ti, logic rs, logic ri);
    rst = 1'b1; mode = m; txs = ts; txi = ti; rxs = rs; rxi = ri;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(tx_strobe,  txi,  "R1 tx");
      chk(rx_strobe,  rxi,  "R1 rx");
      chk(rx_gclk_en, 1'b0, "R1 gclk");
    end
    rst = 1'b0;
    n = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      do_reset(VEC[r][20], VEC[r][19], VEC[r][18], VEC[r][17], VEC[r][16]);
      run(int'(VEC[r][15:0]), "");
    end

    // R12: DS3 to E3 change in mid-frame
    do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run(700, "");
    mode = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(tx_strobe,  txi,  "R12 tx parked");
    chk(rx_strobe,  rxi,  "R12 rx parked");
    chk(rx_gclk_en, 1'b0, "R12 gclk parked");
    n = 0;
    run(1540, " R12");

    // R10 and R11: pin config changes on a live frame
    rxi = ~rxi;
    txs = ~txs;
    step(" R10 R11");
    run(200, " R10");
    txi = ~txi;
    rxs = ~rxs;
    step(" R10 R11");
    run(100, " R11");

    // R12: E3 back to DS3
    mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(tx_strobe,  txi,  "R12 tx parked");
    chk(rx_strobe,  rxi,  "R12 rx parked");
    chk(rx_gclk_en, 1'b0, "R12 gclk parked");
    n = 0;
    run(4770, " R12");

    // R1: reset in mid-frame restarts at bit 0
    run(333, "");
    do_reset(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run(1540, " R1");

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule